// File: doc/BRIEF.md
# 100BASE-TX Transmit Line Encoder

This block turns the two-bit transmit stream of a reduced media-independent interface into the three-level symbol stream that drives a 100BASE-TX line. On the 50 MHz reference clock, each cycle with `txen` high delivers one dibit. Pairs of dibits form nibbles, and each nibble is written into a small gray-pointer FIFO. The FIFO carries the nibbles into the 125 MHz symbol clock domain. There a scheduler frames every packet with start and end delimiters and fills the gaps between packets with idle code groups. Each 5-bit code group is shifted out one bit per symbol clock. The bit then passes through an additive scrambler, an NRZI stage and an MLT3 stage, in that order.

The input side has no ready signal: a transmit interface of this kind cannot be stalled, so the valid qualifier `txen` alone decides what is taken. The FIFO absorbs the two extra delimiter groups that each frame adds at its head. Frames must therefore be separated by idle time, and with the default depth two frames of 16 nibbles each, separated by a single idle reference cycle, pass intact. The output side has no handshake either: one line bit is produced on every symbol clock, always. `scramble_en` is a plain static control that is changed only while the block is held in reset.

Top module: `tx100_line_encoder`

## Requirements
- R1: While either reset is asserted and after its release until the first code bit arrives, `line_mlt3` is 2'b00 and `line_nrzi` is 0.
- R2: On every `ref_clk` rising edge with `txen` high one dibit {txd[1],txd[0]} is taken; the first dibit of a pair is the low half of a nibble and the second dibit is the high half (nibble = {second, first}).
- R3: Data nibbles map to code groups as 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101, and the leftmost code bit is transmitted first.
- R4: Each frame is sent as J (11000), K (10001), its data code groups in arrival order, then T (01101) and R (00111).
- R5: Outside frames the code stream is the idle group 11111; a dibit left unpaired when `txen` falls is dropped, and a burst with no complete nibble produces no frame.
- R6: With `scramble_en` low, each code bit reaches the NRZI stage unchanged.
- R7: With `scramble_en` high, each code bit is XORed with a key bit from an 11-bit LFSR for x^11 + x^9 + 1, seeded to a nonzero value at reset and stepped on every symbol clock, so the key obeys k[n] = k[n-9] XOR k[n-11].
- R8: `line_nrzi` toggles in the symbol clock after a 1 is applied to it and holds after a 0, and it changes in exactly the cycles in which `line_mlt3` changes.
- R9: `line_mlt3` steps through 0, +1, 0, -1 on each line 1 and holds otherwise; encoding 2'b00 = 0, 2'b01 = +1, 2'b11 = -1, and 2'b10 never appears.
- R10: Exactly one line bit leaves per symbol clock and one code group spans five; two frames of 16 nibbles each, separated by a single idle reference cycle, both arrive intact with their own delimiters, and the scheduler never pops an empty FIFO.
- R11: With frames spaced as in R10, the reference-side writer never offers a word to a full FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | 50 MHz transmit reference clock |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| txen | input | 1 | Transmit valid qualifier for `txd` |
| txd | input | 2 | Transmit dibit, bit 0 carries the earlier bit |
| sym_clk | input | 1 | 125 MHz symbol clock |
| sym_rst_n | input | 1 | Active-low asynchronous reset, symbol domain |
| scramble_en | input | 1 | Static enable for the additive scrambler |
| line_nrzi | output | 1 | NRZI-coded line bit |
| line_mlt3 | output | 2 | Three-level line symbol, signed two-bit code |

## Verification
The close race is between the end of one frame and the start of the next. In that window the scheduler turns the end marker into T and R while the reference side is already writing the first nibbles of the next frame into the same FIFO. The case is provoked by two frames of 16 nibbles each, separated by one idle reference cycle. It is judged by decoding the line back into bits and requiring two complete J/K…T/R frames whose 32 nibbles match what was sent. The scrambler is judged by learning its key from idle bits and checking that the key keeps following the polynomial recurrence, both through idle time and through a whole frame.

// File: rtl/tx100_pkg.sv
package tx100_pkg;

  localparam int CG_BITS = 5;
  localparam int LFSR_W  = 11;

  localparam logic [CG_BITS-1:0] CG_IDLE = 5'b11111;
  localparam logic [CG_BITS-1:0] CG_J    = 5'b11000;
  localparam logic [CG_BITS-1:0] CG_K    = 5'b10001;
  localparam logic [CG_BITS-1:0] CG_T    = 5'b01101;
  localparam logic [CG_BITS-1:0] CG_R    = 5'b00111;

  typedef enum logic [1:0] {SCH_IDLE, SCH_K, SCH_DATA, SCH_R} sch_state_t;

  // one FIFO word: end-of-frame marker or a data nibble
  typedef struct packed {
    logic       last;
    logic [3:0] nib;
  } txq_word_t;

  function automatic logic [CG_BITS-1:0] enc_4b5b(input logic [3:0] n);
    logic [CG_BITS-1:0] c;
    case (n)
      4'h0: c = 5'b11110; 4'h1: c = 5'b01001; 4'h2: c = 5'b10100; 4'h3: c = 5'b10101;
      4'h4: c = 5'b01010; 4'h5: c = 5'b01011; 4'h6: c = 5'b01110; 4'h7: c = 5'b01111;
      4'h8: c = 5'b10010; 4'h9: c = 5'b10011; 4'hA: c = 5'b10110; 4'hB: c = 5'b10111;
      4'hC: c = 5'b11010; 4'hD: c = 5'b11011; 4'hE: c = 5'b11100; default: c = 5'b11101;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/rmii_nibble_packer.sv
module rmii_nibble_packer
  import tx100_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txen,
  input  logic [1:0] txd,
  output logic       wr_req,
  output txq_word_t  wr_word
);

  logic       second_q;
  logic [1:0] low_q;
  logic       txen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q <= 1'b0;
      low_q    <= '0;
      txen_q   <= 1'b0;
    end else begin
      txen_q <= txen;
      if (txen) begin
        second_q <= ~second_q;
        if (!second_q) low_q <= txd;
      end else begin
        second_q <= 1'b0;
      end
    end
  end

  // a nibble completes on the second dibit; the falling edge of txen queues an end marker
  always_comb begin
    wr_req       = (txen && second_q) || (!txen && txen_q);
    wr_word.last = !txen;
    wr_word.nib  = txen ? {txd, low_q} : 4'h0;
  end

endmodule

// File: rtl/cdc_gray_fifo.sv
module cdc_gray_fifo #(
  parameter int W      = 5,
  parameter int AW     = 4,
  parameter int SYNC_N = 2
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic         wfull,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         rd_en,
  output logic [W-1:0] rdata,
  output logic         rempty
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wbin, wgray, rbin, rgray;
  logic [AW:0]  rg_sync [SYNC_N];
  logic [AW:0]  wg_sync [SYNC_N];
  logic [AW:0]  wbin_nx, rbin_nx;

  assign wbin_nx = wbin + 1'b1;
  assign rbin_nx = rbin + 1'b1;

  // write side
  assign wfull = (wgray == {~rg_sync[SYNC_N-1][AW:AW-1], rg_sync[SYNC_N-1][AW-2:0]});

  always_ff @(posedge wclk) begin
    if (wr_en && !wfull) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
      for (int i = 0; i < SYNC_N; i++) rg_sync[i] <= '0;
    end else begin
      if (wr_en && !wfull) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
      rg_sync[0] <= rgray;
      for (int i = 1; i < SYNC_N; i++) rg_sync[i] <= rg_sync[i-1];
    end
  end

  // read side, head word shown while not empty
  assign rempty = (rgray == wg_sync[SYNC_N-1]);
  assign rdata  = mem[rbin[AW-1:0]];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
      for (int i = 0; i < SYNC_N; i++) wg_sync[i] <= '0;
    end else begin
      if (rd_en && !rempty) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
      wg_sync[0] <= wgray;
      for (int i = 1; i < SYNC_N; i++) wg_sync[i] <= wg_sync[i-1];
    end
  end

endmodule

// File: rtl/pcs_symbol_sched.sv
module pcs_symbol_sched
  import tx100_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      q_empty,
  input  txq_word_t q_head,
  output logic      q_pop,
  output logic      code_bit
);

  localparam int CNT_W = $clog2(CG_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CG_BITS - 1);

  sch_state_t         state_q, state_nx;
  logic [CNT_W-1:0]   bit_cnt;
  logic [CG_BITS-1:0] shreg, sym_nx;
  logic               want_pop;

  always_comb begin
    state_nx = state_q;
    sym_nx   = CG_IDLE;
    want_pop = 1'b0;
    case (state_q)
      SCH_IDLE: begin
        if (!q_empty && !q_head.last) begin
          sym_nx   = CG_J;
          state_nx = SCH_K;
        end else if (!q_empty) begin
          want_pop = 1'b1;             // stray end marker of an empty burst
        end
      end
      SCH_K: begin
        sym_nx   = CG_K;
        state_nx = SCH_DATA;
      end
      SCH_DATA: begin
        if (!q_empty) begin
          want_pop = 1'b1;
          if (q_head.last) begin
            sym_nx   = CG_T;
            state_nx = SCH_R;
          end else begin
            sym_nx = enc_4b5b(q_head.nib);
          end
        end
      end
      default: begin
        sym_nx   = CG_R;
        state_nx = SCH_IDLE;
      end
    endcase
  end

  assign q_pop    = want_pop && (bit_cnt == LAST_BIT);
  assign code_bit = shreg[CG_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCH_IDLE;
      bit_cnt <= '0;
      shreg   <= CG_IDLE;
    end else if (bit_cnt == LAST_BIT) begin
      state_q <= state_nx;
      bit_cnt <= '0;
      shreg   <= sym_nx;
    end else begin
      bit_cnt <= bit_cnt + 1'b1;
      shreg   <= {shreg[CG_BITS-2:0], 1'b1};
    end
  end

endmodule

// File: rtl/line_coder.sv
module line_coder
  import tx100_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 11'h2A5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scramble_en,
  input  logic       code_bit,
  output logic       nrzi,
  output logic [1:0] mlt3
);

  logic [LFSR_W-1:0] lfsr;
  logic              key, scr_q;
  logic [1:0]        phase;

  assign key = lfsr[LFSR_W-1] ^ lfsr[LFSR_W-3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr  <= SEED;
      scr_q <= 1'b0;
      nrzi  <= 1'b0;
      phase <= '0;
    end else begin
      lfsr  <= {lfsr[LFSR_W-2:0], key};
      scr_q <= code_bit ^ (scramble_en & key);
      nrzi  <= nrzi ^ scr_q;
      phase <= phase + {1'b0, scr_q};
    end
  end

  always_comb begin
    case (phase)
      2'd1:    mlt3 = 2'b01;
      2'd3:    mlt3 = 2'b11;
      default: mlt3 = 2'b00;
    endcase
  end

endmodule

// File: rtl/tx100_line_encoder.sv
module tx100_line_encoder
  import tx100_pkg::*;
#(
  parameter int                FIFO_AW  = 4,
  parameter int                SYNC_N   = 2,
  parameter logic [LFSR_W-1:0] SCR_SEED = 11'h2A5
) (
  input  logic       ref_clk,
  input  logic       ref_rst_n,
  input  logic       txen,
  input  logic [1:0] txd,
  input  logic       sym_clk,
  input  logic       sym_rst_n,
  input  logic       scramble_en,
  output logic       line_nrzi,
  output logic [1:0] line_mlt3
);

  localparam int QW = $bits(txq_word_t);

  logic      q_wr, q_full, q_pop, q_empty, code_bit;
  txq_word_t q_in, q_head;

  rmii_nibble_packer i_pack (
    .clk(ref_clk), .rst_n(ref_rst_n), .txen(txen), .txd(txd),
    .wr_req(q_wr), .wr_word(q_in)
  );

  cdc_gray_fifo #(.W(QW), .AW(FIFO_AW), .SYNC_N(SYNC_N)) i_fifo (
    .wclk(ref_clk), .wrst_n(ref_rst_n), .wr_en(q_wr), .wdata(q_in), .wfull(q_full),
    .rclk(sym_clk), .rrst_n(sym_rst_n), .rd_en(q_pop), .rdata(q_head), .rempty(q_empty)
  );

  pcs_symbol_sched i_sched (
    .clk(sym_clk), .rst_n(sym_rst_n), .q_empty(q_empty), .q_head(q_head),
    .q_pop(q_pop), .code_bit(code_bit)
  );

  line_coder #(.SEED(SCR_SEED)) i_line (
    .clk(sym_clk), .rst_n(sym_rst_n), .scramble_en(scramble_en), .code_bit(code_bit),
    .nrzi(line_nrzi), .mlt3(line_mlt3)
  );

endmodule

// File: rtl/tx100_line_encoder_chk.sv
module tx100_line_encoder_chk (
  input logic       ref_clk,
  input logic       ref_rst_n,
  input logic       sym_clk,
  input logic       sym_rst_n,
  input logic       q_wr,
  input logic       q_full,
  input logic       q_pop,
  input logic       q_empty,
  input logic       line_nrzi,
  input logic [1:0] line_mlt3
);

  // R11
  no_overflow_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    q_wr |-> !q_full);

  // R10
  no_underflow_chk: assert property (@(posedge sym_clk) disable iff (!sym_rst_n)
    q_pop |-> !q_empty);

  // R9
  mlt3_code_chk: assert property (@(posedge sym_clk) disable iff (!sym_rst_n)
    line_mlt3 != 2'b10);

  // R9
  mlt3_up_chk: assert property (@(posedge sym_clk) disable iff (!sym_rst_n)
    ($past(line_mlt3) == 2'b01) |-> (line_mlt3 != 2'b11));

  // R9
  mlt3_down_chk: assert property (@(posedge sym_clk) disable iff (!sym_rst_n)
    ($past(line_mlt3) == 2'b11) |-> (line_mlt3 != 2'b01));

  // R8
  nrzi_mlt3_chk: assert property (@(posedge sym_clk) disable iff (!sym_rst_n)
    (line_nrzi != $past(line_nrzi)) == (line_mlt3 != $past(line_mlt3)));

endmodule

bind tx100_line_encoder tx100_line_encoder_chk i_chk (
  .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .sym_clk(sym_clk), .sym_rst_n(sym_rst_n),
  .q_wr(q_wr), .q_full(q_full), .q_pop(q_pop), .q_empty(q_empty),
  .line_nrzi(line_nrzi), .line_mlt3(line_mlt3)
);

// File: tb/test_tx100_line_encoder.sv
module test_tx100_line_encoder;

  logic       clk = 1'b0;
  logic       sym_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic [2:0] div5 = '0;
  logic       rst_n = 1'b0;
  logic       txen = 1'b0;
  logic [1:0] txd = '0;
  logic       scramble_en = 1'b0;
  logic       line_nrzi;
  logic [1:0] line_mlt3;

  int tests = 0, fails = 0, wd = 0;

  initial forever #2 clk = ~clk;   // 250 MHz

  always @(posedge clk) begin
    sym_clk <= ~sym_clk;
    div5    <= (div5 == 3'd4) ? 3'd0 : div5 + 3'd1;
    ref_clk <= (div5 == 3'd4) || (div5 == 3'd0);
  end

  tx100_line_encoder i_tx100_line_encoder (
    .ref_clk(ref_clk), .ref_rst_n(rst_n), .txen(txen), .txd(txd),
    .sym_clk(sym_clk), .sym_rst_n(rst_n), .scramble_en(scramble_en),
    .line_nrzi(line_nrzi), .line_mlt3(line_mlt3)
  );

  // expected code groups (R3)
  function automatic logic [4:0] cg(input int v);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
                           5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[v];
  endfunction

  function automatic int dec(input logic [4:0] s);
    for (int v = 0; v < 16; v++) if (cg(v) == s) return v;
    return -1;
  endfunction

  function automatic logic [1:0] lvl(input logic [1:0] p);
    return (p == 2'd1) ? 2'b01 : (p == 2'd3) ? 2'b11 : 2'b00;
  endfunction

  // line monitor state
  logic       scr_on = 1'b0;
  logic [1:0] prev_m, bph;
  logic       prev_n, rb, key, d;
  logic [10:0] kh;
  logic [9:0] win;
  logic [4:0] sym;
  int nbit, pmode, scnt, dv;
  int rx_cnt = 0, exp_cnt = 0, frames_done = 0, dec_err = 0;
  int zero_cnt = 0, raw_zero = 0, mlt_err = 0, nrzi_err = 0;
  logic [3:0] rx_nib [256];
  logic [3:0] exp_nib [256];

  always @(negedge sym_clk) begin
    if (!rst_n) begin
      prev_m = 2'b00; prev_n = 1'b0; bph = 2'd0; nbit = 0; kh = '0;
      win = '0; pmode = 0; scnt = 0; sym = '0;
    end else begin
      rb = (line_mlt3 != prev_m);
      if (rb != (line_nrzi != prev_n)) nrzi_err++;
      if (line_mlt3 == 2'b10) mlt_err++;
      if (rb) begin
        bph = bph + 2'd1;
        if (line_mlt3 != lvl(bph)) mlt_err++;
      end
      prev_m = line_mlt3;
      prev_n = line_nrzi;
      if (nbit >= 4) begin
        if (nbit < 15) key = scr_on ? ~rb : 1'b0;        // learn key from idle ones
        else           key = scr_on ? (kh[10] ^ kh[8]) : 1'b0;
        kh = {kh[9:0], key};
        if (nbit >= 15) begin
          d = rb ^ key;
          if (!rb) raw_zero++;
          if (pmode == 0) begin
            if (!d) zero_cnt++;
            win = {win[8:0], d};
            if (win == 10'b1100010001) begin pmode = 1; scnt = 0; end
          end else begin
            sym = {sym[3:0], d};
            scnt++;
            if (scnt == 5) begin
              scnt = 0;
              if (pmode == 1) begin
                if (sym == 5'b01101) pmode = 2;
                else begin
                  dv = dec(sym);
                  if (dv < 0) dec_err++;
                  else if (rx_cnt < 256) begin rx_nib[rx_cnt] = dv[3:0]; rx_cnt++; end
                end
              end else begin
                if (sym == 5'b00111) frames_done++; else dec_err++;
                pmode = 0;
                win = '0;
              end
            end
          end
        end
      end
      nbit++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    rx_cnt = 0; exp_cnt = 0; frames_done = 0; dec_err = 0; zero_cnt = 0; raw_zero = 0;
  endtask

  task automatic do_reset(input logic scr);
    rst_n = 1'b0;
    txen = 1'b0;
    txd = '0;
    scramble_en = scr;
    scr_on = scr;
    repeat (12) @(posedge clk);
    #1;
    // R1 reset values
    chk(line_mlt3 == 2'b00, "R1 mlt3 in reset", int'(line_mlt3), 0);
    chk(line_nrzi == 1'b0, "R1 nrzi in reset", int'(line_nrzi), 0);
    @(negedge ref_clk);
    rst_n = 1'b1;
    repeat (40) @(negedge sym_clk);
    clear_counts();
  endtask

  task automatic send_nibs(input int n, input logic [63:0] data);
    logic [3:0] nb;
    for (int i = 0; i < n; i++) begin
      nb = data[4*i +: 4];
      exp_nib[exp_cnt] = nb;
      exp_cnt++;
      @(negedge ref_clk); txen = 1'b1; txd = nb[1:0];   // low dibit first (R2)
      @(negedge ref_clk); txd = nb[3:2];
    end
    @(negedge ref_clk); txen = 1'b0; txd = '0;
  endtask

  task automatic verify(input string rf, input string rd, input int expf);
    int mism;
    repeat (300) @(negedge sym_clk);
    chk(frames_done == expf && dec_err == 0, rf, frames_done * 100 + dec_err, expf * 100);
    mism = (rx_cnt != exp_cnt) ? 1 : 0;
    for (int i = 0; i < exp_cnt && i < rx_cnt; i++) if (rx_nib[i] != exp_nib[i]) mism++;
    chk(mism == 0, rd, rx_cnt, exp_cnt);
    clear_counts();
  endtask

  // {nibble count, data (nibble 0 in bits 3:0)}
  localparam logic [71:0] VEC [6] = '{
    {8'd1,  64'h0000_0000_0000_0005},
    {8'd2,  64'h0000_0000_0000_00A3},
    {8'd4,  64'h0000_0000_0000_F00F},
    {8'd8,  64'h0000_0000_8967_4523},
    {8'd16, 64'h0123_4567_89AB_CDEF},
    {8'd16, 64'hFFFF_FFFF_0000_0000}
  };

  bit done = 0;

  initial begin
    do_reset(1'b0);

    // R5 R6: idle, unscrambled, is all ones
    repeat (100) @(negedge sym_clk);
    chk(raw_zero == 0, "R5 R6 idle line bits all ones", raw_zero, 0);
    clear_counts();

    for (int v = 0; v < 6; v++) begin
      send_nibs(int'(VEC[v][71:64]), VEC[v][63:0]);
      verify("R4 delimiters J K .. T R", "R2 R3 nibble codes", 1);
    end

    // R5: trailing unpaired dibit dropped
    exp_nib[0] = 4'h6; exp_cnt = 1;
    @(negedge ref_clk); txen = 1'b1; txd = 2'b10;
    @(negedge ref_clk); txd = 2'b01;
    @(negedge ref_clk); txd = 2'b11;
    @(negedge ref_clk); txen = 1'b0; txd = '0;
    verify("R5 odd dibit frame", "R5 odd dibit content", 1);

    // R5: burst with no complete nibble gives no frame
    @(negedge ref_clk); txen = 1'b1; txd = 2'b00;
    @(negedge ref_clk); txen = 1'b0;
    repeat (300) @(negedge sym_clk);
    chk(frames_done == 0 && zero_cnt == 0, "R5 lone dibit no frame", frames_done * 100 + zero_cnt, 0);
    clear_counts();

    // R10 R11: back-to-back frames, one idle reference cycle apart
    send_nibs(16, 64'h1357_9BDF_0246_8ACE);
    send_nibs(16, 64'hC3A5_5A3C_9669_0FF0);
    verify("R10 R11 back-to-back frames", "R10 back-to-back content", 2);

    // R7: scrambler key keeps the polynomial recurrence in idle
    do_reset(1'b1);
    repeat (400) @(negedge sym_clk);
    chk(zero_cnt == 0, "R7 key recurrence in idle", zero_cnt, 0);
    chk(raw_zero > 0, "R7 scrambled line differs from idle", raw_zero, 1);
    clear_counts();
    send_nibs(16, 64'hDEAD_BEEF_0BAD_F00D);
    verify("R7 scrambled frame", "R7 descrambled content", 1);

    // R8 R9 line coding legality over the whole run
    chk(nrzi_err == 0, "R8 nrzi tracks mlt3 steps", nrzi_err, 0);
    chk(mlt_err == 0, "R9 mlt3 level sequence", mlt_err, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule